// File: doc/BRIEF.md
# Multi-Channel Frame FIFO Register Front End

This block sits between a host bus and a small set of byte FIFOs that carry HDLC frames for several ISDN channels. The host picks one FIFO with a selection register. Every other register then acts on that FIFO: a data port, the write and read byte pointers, and a pair of frame counters, one for frames entered and one for frames taken out. The block does no framing, CRC or bit stuffing. It keeps the pointers, the counters and the byte storage, and it applies the side effects that bus accesses have on them.

Each FIFO is a circular buffer with its own write pointer (input side) and read pointer (output side). A data-port write stores a byte and moves the write pointer on. A data-port read returns a byte and moves the read pointer on. The frame counters never move on their own. Each one moves only when the host reads its dedicated step register. An input pin turns frame counting off for transparent (non-HDLC) traffic.

The parameter `BUS_DIRECT` chooses one of two bus variants. The indexed variant has an internal index register that is loaded through address bit 0, and later data cycles go to the indexed register. The direct variant decodes the register from the whole address.

Top module: `frame_fifo_regs`

## Requirements
- R1: After reset, every pointer, frame counter, the FIFO selection and the index register are zero, and `rdata` is 0x00.
- R2: In the indexed variant (`BUS_DIRECT`=0), a write with `addr[0]`=1 loads the index register from `wdata`. Every access with `addr[0]`=0 targets the indexed register until the index is rewritten. A read with `addr[0]`=1 returns the index register.
- R3: In the direct variant (`BUS_DIRECT`=1), `addr[7:0]` is the register index, and no index register is involved.
- R4: Register 0x00 is the read/write selection. Bits [1:0] pick the FIFO (for 4 FIFOs), and the remaining bits are ignored and read back as 0. Writing the selection changes no pointer or frame counter of any FIFO.
- R5: A write to the data port (0x09) stores the byte at the selected FIFO's write pointer and then advances that pointer by one. The pointer wraps from 511 to 0.
- R6: A data-port write is refused when advancing the write pointer would make it equal to the read pointer. In that case no byte is stored and the write pointer stays unchanged.
- R7: A read of the data port (0x09) returns the byte at the read pointer and advances the read pointer by one. When the read pointer equals the write pointer, the read pointer stays unchanged.
- R8: While `hdlc_en`=1, a read of 0x07 advances the input frame counter and a read of 0x08 advances the output frame counter. Both counters are 4 bits wide and wrap modulo 16, and both step reads return 0x00. Register 0x05 returns the input frame counter and 0x06 returns the output frame counter.
- R9: While `hdlc_en`=0, reads of 0x07 and 0x08 leave both frame counters unchanged.
- R10: Register 0x01 returns bits [7:0] of the write pointer and 0x03 returns bits [7:0] of the read pointer. Reading either one latches that pointer's upper bits. The high registers (0x02 for the write pointer, 0x04 for the read pointer) return the latched upper bits, zero-extended, even if the pointer has moved since the latch.
- R11: Read data appears on `rdata` in the cycle after the access and holds until the next read. Unmapped indices read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdlc_en | input | 1 | 1 = frame counters may step; 0 = transparent traffic |
| cs | input | 1 | Bus access strobe, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Register address (bit 0 only in indexed variant) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |

## Verification
The bench builds two copies with the default shape of 4 FIFOs, 9-bit pointers and 4-bit frame counters: one with `BUS_DIRECT`=0 and one with `BUS_DIRECT`=1. Both variants therefore see the same register behaviour. With 512-byte buffers the bench can fill a FIFO to the refusal point, wrap both pointers across 511 to 0 and observe a nonzero high-pointer byte, all in a few thousand cycles. The 4-bit counters let it wrap a frame counter with sixteen step reads.

// File: rtl/ffr_pkg.sv
package ffr_pkg;

   localparam int BUS_W = 8;

   typedef enum logic [BUS_W-1:0] {
      REG_SEL       = 8'h00,
      REG_WPTR_LO   = 8'h01,
      REG_WPTR_HI   = 8'h02,
      REG_RPTR_LO   = 8'h03,
      REG_RPTR_HI   = 8'h04,
      REG_IFRM      = 8'h05,
      REG_OFRM      = 8'h06,
      REG_IFRM_STEP = 8'h07,
      REG_OFRM_STEP = 8'h08,
      REG_DPORT     = 8'h09
   } reg_idx_e;

   function automatic logic hits(input logic [BUS_W-1:0] idx, input reg_idx_e r);
      return idx == r;
   endfunction

endpackage

// File: rtl/ffr_bus_decode.sv
module ffr_bus_decode #(
   parameter bit BUS_DIRECT = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs,
   input  logic                     we,
   input  logic [ffr_pkg::BUS_W-1:0] addr,
   input  logic [ffr_pkg::BUS_W-1:0] wdata,
   output logic                     acc_vld,
   output logic                     acc_we,
   output logic [ffr_pkg::BUS_W-1:0] acc_reg,
   output logic                     idx_rd,
   output logic [ffr_pkg::BUS_W-1:0] idx_q
);
   localparam int BW = ffr_pkg::BUS_W;

   logic [BW-1:0] idx_r;

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_r <= '0;
      else if (!BUS_DIRECT && cs && we && addr[0])
         idx_r <= wdata;
   end

   assign idx_q  = idx_r;
   assign acc_we = we;

   generate
      if (BUS_DIRECT) begin : g_direct
         assign acc_vld = cs;
         assign acc_reg = addr;
         assign idx_rd  = 1'b0;
      end else begin : g_indexed
         logic unused_hi_addr;
         assign unused_hi_addr = ^addr[BW-1:1];
         assign acc_vld = cs & ~addr[0];
         assign acc_reg = idx_r;
         assign idx_rd  = cs & ~we & addr[0];
      end
   endgenerate

endmodule

// File: rtl/ffr_ptr_bank.sv
module ffr_ptr_bank #(
   parameter int NUM_FIFO = 4,
   parameter int Z_W      = 9,
   parameter int F_W      = 4,
   parameter int SEL_W    = $clog2(NUM_FIFO)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [SEL_W-1:0]        sel,
   input  logic                    push,
   input  logic                    pop,
   input  logic                    f1_step,
   input  logic                    f2_step,
   output logic [Z_W-1:0]          z1_cur,
   output logic [Z_W-1:0]          z2_cur,
   output logic [F_W-1:0]          f1_cur,
   output logic [F_W-1:0]          f2_cur,
   output logic                    push_ok,
   output logic [NUM_FIFO*Z_W-1:0] z1_all,
   output logic [NUM_FIFO*Z_W-1:0] z2_all,
   output logic [NUM_FIFO*F_W-1:0] f1_all,
   output logic [NUM_FIFO*F_W-1:0] f2_all
);
   logic [Z_W-1:0] z1_r [NUM_FIFO];
   logic [Z_W-1:0] z2_r [NUM_FIFO];
   logic [F_W-1:0] f1_r [NUM_FIFO];
   logic [F_W-1:0] f2_r [NUM_FIFO];
   logic           pop_ok;

   assign z1_cur  = z1_r[sel];
   assign z2_cur  = z2_r[sel];
   assign f1_cur  = f1_r[sel];
   assign f2_cur  = f2_r[sel];
   assign push_ok = Z_W'(z1_cur + 1'b1) != z2_cur;
   assign pop_ok  = z2_cur != z1_cur;

   generate
      for (genvar g = 0; g < NUM_FIFO; g++) begin : g_fifo
         logic here;
         assign here = (sel == SEL_W'(g));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               z1_r[g] <= '0;
               z2_r[g] <= '0;
               f1_r[g] <= '0;
               f2_r[g] <= '0;
            end else if (here) begin
               if (push && push_ok) z1_r[g] <= z1_r[g] + 1'b1;
               if (pop && pop_ok)   z2_r[g] <= z2_r[g] + 1'b1;
               if (f1_step)         f1_r[g] <= f1_r[g] + 1'b1;
               if (f2_step)         f2_r[g] <= f2_r[g] + 1'b1;
            end
         end

         assign z1_all[g*Z_W +: Z_W] = z1_r[g];
         assign z2_all[g*Z_W +: Z_W] = z2_r[g];
         assign f1_all[g*F_W +: F_W] = f1_r[g];
         assign f2_all[g*F_W +: F_W] = f2_r[g];
      end
   endgenerate

endmodule

// File: rtl/ffr_byte_ram.sv
module ffr_byte_ram #(
   parameter int DEPTH = 2048,
   parameter int AW    = 11,
   parameter int DW    = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/frame_fifo_regs.sv
module frame_fifo_regs #(
   parameter int NUM_FIFO   = 4,
   parameter int Z_W        = 9,
   parameter int F_W        = 4,
   parameter bit BUS_DIRECT = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hdlc_en,
   input  logic       cs,
   input  logic       we,
   input  logic [7:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata
);
   import ffr_pkg::*;

   localparam int SEL_W = $clog2(NUM_FIFO);
   localparam int HI_W  = Z_W - 8;
   localparam int RA_W  = SEL_W + Z_W;
   localparam int DEPTH = NUM_FIFO << Z_W;

   generate
      if (NUM_FIFO < 2 || NUM_FIFO > 16 || (NUM_FIFO & (NUM_FIFO - 1)) != 0) begin : g_bad_num
         $error("NUM_FIFO must be a power of two from 2 to 16");
      end
      if (Z_W < 9 || Z_W > 16) begin : g_bad_zw
         $error("Z_W must lie between 9 and 16");
      end
      if (F_W < 1 || F_W > 8) begin : g_bad_fw
         $error("F_W must lie between 1 and 8");
      end
   endgenerate

   logic             acc_vld, acc_we, idx_rd;
   logic [BUS_W-1:0] acc_reg, idx_q;

   ffr_bus_decode #(.BUS_DIRECT(BUS_DIRECT)) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs      (cs),
      .we      (we),
      .addr    (addr),
      .wdata   (wdata),
      .acc_vld (acc_vld),
      .acc_we  (acc_we),
      .acc_reg (acc_reg),
      .idx_rd  (idx_rd),
      .idx_q   (idx_q)
   );

   logic wr_acc, rd_acc, rd_any;
   logic wr_sel, wr_dport, rd_dport, f1_step, f2_step;

   assign wr_acc   = acc_vld & acc_we;
   assign rd_acc   = acc_vld & ~acc_we;
   assign rd_any   = rd_acc | idx_rd;
   assign wr_sel   = wr_acc & hits(acc_reg, REG_SEL);
   assign wr_dport = wr_acc & hits(acc_reg, REG_DPORT);
   assign rd_dport = rd_acc & hits(acc_reg, REG_DPORT);
   assign f1_step  = rd_acc & hdlc_en & hits(acc_reg, REG_IFRM_STEP);
   assign f2_step  = rd_acc & hdlc_en & hits(acc_reg, REG_OFRM_STEP);

   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      sel_q <= '0;
      else if (wr_sel) sel_q <= wdata[SEL_W-1:0];
   end

   logic [Z_W-1:0]          z1_cur, z2_cur;
   logic [F_W-1:0]          f1_cur, f2_cur;
   logic                    push_ok;
   logic [NUM_FIFO*Z_W-1:0] z1_all, z2_all;
   logic [NUM_FIFO*F_W-1:0] f1_all, f2_all;

   ffr_ptr_bank #(
      .NUM_FIFO (NUM_FIFO),
      .Z_W      (Z_W),
      .F_W      (F_W),
      .SEL_W    (SEL_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel_q),
      .push    (wr_dport),
      .pop     (rd_dport),
      .f1_step (f1_step),
      .f2_step (f2_step),
      .z1_cur  (z1_cur),
      .z2_cur  (z2_cur),
      .f1_cur  (f1_cur),
      .f2_cur  (f2_cur),
      .push_ok (push_ok),
      .z1_all  (z1_all),
      .z2_all  (z2_all),
      .f1_all  (f1_all),
      .f2_all  (f2_all)
   );

   logic [BUS_W-1:0] ram_q;

   ffr_byte_ram #(.DEPTH(DEPTH), .AW(RA_W), .DW(BUS_W)) u_ram (
      .clk   (clk),
      .we    (wr_dport & push_ok),
      .waddr ({sel_q, z1_cur}),
      .wdata (wdata),
      .re    (rd_dport),
      .raddr ({sel_q, z2_cur}),
      .rdata (ram_q)
   );

   logic [HI_W-1:0] z1_hi_lat, z2_hi_lat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         z1_hi_lat <= '0;
         z2_hi_lat <= '0;
      end else begin
         if (rd_acc && hits(acc_reg, REG_WPTR_LO)) z1_hi_lat <= z1_cur[Z_W-1:8];
         if (rd_acc && hits(acc_reg, REG_RPTR_LO)) z2_hi_lat <= z2_cur[Z_W-1:8];
      end
   end

   logic [BUS_W-1:0] rd_val;

   always_comb begin
      rd_val = '0;
      case (acc_reg)
         REG_SEL:     rd_val = BUS_W'(sel_q);
         REG_WPTR_LO: rd_val = z1_cur[7:0];
         REG_WPTR_HI: rd_val = BUS_W'(z1_hi_lat);
         REG_RPTR_LO: rd_val = z2_cur[7:0];
         REG_RPTR_HI: rd_val = BUS_W'(z2_hi_lat);
         REG_IFRM:    rd_val = BUS_W'(f1_cur);
         REG_OFRM:    rd_val = BUS_W'(f2_cur);
         default:     rd_val = '0;
      endcase
   end

   logic [BUS_W-1:0] reg_q;
   logic             from_ram_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_q      <= '0;
         from_ram_q <= 1'b0;
      end else if (rd_any) begin
         reg_q      <= idx_rd ? idx_q : rd_val;
         from_ram_q <= rd_dport;
      end
   end

   assign rdata = from_ram_q ? ram_q : reg_q;

endmodule

// File: rtl/ffr_chk.sv
module ffr_chk #(
   parameter int NUM_FIFO = 4,
   parameter int Z_W      = 9,
   parameter int F_W      = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    hdlc_en,
   input logic                    wr_sel,
   input logic                    wr_dport,
   input logic                    rd_dport,
   input logic                    rd_any,
   input logic [Z_W-1:0]          z1_cur,
   input logic [Z_W-1:0]          z2_cur,
   input logic [NUM_FIFO*Z_W-1:0] z1_all,
   input logic [NUM_FIFO*Z_W-1:0] z2_all,
   input logic [NUM_FIFO*F_W-1:0] f1_all,
   input logic [NUM_FIFO*F_W-1:0] f2_all,
   input logic [7:0]              rdata
);

   AST_SEL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel |=> ($stable(z1_all) && $stable(z2_all) && $stable(f1_all) && $stable(f2_all))); // R4

   AST_PUSH_NEVER_MEETS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dport |=> (z1_cur != z2_cur)); // R6

   AST_POP_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_dport |=> ((z2_cur == $past(z2_cur)) || (z2_cur == Z_W'($past(z2_cur) + 1'b1)))); // R7

   AST_POP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_dport && (z1_cur == z2_cur)) |=> $stable(z2_all)); // R7

   AST_FRAME_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !hdlc_en |=> ($stable(f1_all) && $stable(f2_all))); // R9

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_any |=> $stable(rdata)); // R11

endmodule

bind frame_fifo_regs ffr_chk #(
   .NUM_FIFO (NUM_FIFO),
   .Z_W      (Z_W),
   .F_W      (F_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hdlc_en  (hdlc_en),
   .wr_sel   (wr_sel),
   .wr_dport (wr_dport),
   .rd_dport (rd_dport),
   .rd_any   (rd_any),
   .z1_cur   (z1_cur),
   .z2_cur   (z2_cur),
   .z1_all   (z1_all),
   .z2_all   (z2_all),
   .f1_all   (f1_all),
   .f2_all   (f2_all),
   .rdata    (rdata)
);

// File: tb/tb_frame_fifo_regs.sv
module tb_frame_fifo_regs;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hdlc_en = 1'b1;
   logic       cs_i = 1'b0;
   logic       cs_d = 1'b0;
   logic       we = 1'b0;
   logic [7:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata_i, rdata_d;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   frame_fifo_regs #(.BUS_DIRECT(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .hdlc_en(hdlc_en), .cs(cs_i), .we(we),
      .addr(addr), .wdata(wdata), .rdata(rdata_i)
   );

   frame_fifo_regs #(.BUS_DIRECT(1'b1)) dut_dir (
      .clk(clk), .rst_n(rst_n), .hdlc_en(hdlc_en), .cs(cs_d), .we(we),
      .addr(addr), .wdata(wdata), .rdata(rdata_d)
   );

   // Vector: [22] write, [21] addr bit 0, [20:13] wdata, [12] check, [11:4] expected, [3:0] requirement
   localparam int NV = 37;
   localparam logic [22:0] VEC [NV] = '{
      {1'b1,1'b1,8'h09,1'b0,8'h00,4'd5},  // R5 index -> data port
      {1'b1,1'b0,8'h11,1'b0,8'h00,4'd5},
      {1'b1,1'b0,8'h22,1'b0,8'h00,4'd5},
      {1'b1,1'b0,8'h33,1'b0,8'h00,4'd5},
      {1'b1,1'b1,8'h01,1'b0,8'h00,4'd10}, // R10 write pointer low
      {1'b0,1'b0,8'h00,1'b1,8'h03,4'd10},
      {1'b0,1'b0,8'h00,1'b1,8'h03,4'd2},  // R2 index stays
      {1'b1,1'b1,8'h02,1'b0,8'h00,4'd10},
      {1'b0,1'b0,8'h00,1'b1,8'h00,4'd10},
      {1'b1,1'b1,8'h09,1'b0,8'h00,4'd7},  // R7 pops
      {1'b0,1'b0,8'h00,1'b1,8'h11,4'd7},
      {1'b0,1'b0,8'h00,1'b1,8'h22,4'd7},
      {1'b1,1'b1,8'h03,1'b0,8'h00,4'd7},
      {1'b0,1'b0,8'h00,1'b1,8'h02,4'd7},
      {1'b1,1'b1,8'h07,1'b0,8'h00,4'd8},  // R8 input frame steps
      {1'b0,1'b0,8'h00,1'b1,8'h00,4'd8},
      {1'b0,1'b0,8'h00,1'b1,8'h00,4'd8},
      {1'b1,1'b1,8'h05,1'b0,8'h00,4'd8},
      {1'b0,1'b0,8'h00,1'b1,8'h02,4'd8},
      {1'b1,1'b1,8'h08,1'b0,8'h00,4'd8},
      {1'b0,1'b0,8'h00,1'b1,8'h00,4'd8},
      {1'b1,1'b1,8'h06,1'b0,8'h00,4'd8},
      {1'b0,1'b0,8'h00,1'b1,8'h01,4'd8},
      {1'b1,1'b1,8'h00,1'b0,8'h00,4'd4},  // R4 select FIFO 1
      {1'b1,1'b0,8'hFD,1'b0,8'h00,4'd4},
      {1'b0,1'b0,8'h00,1'b1,8'h01,4'd4},
      {1'b1,1'b1,8'h01,1'b0,8'h00,4'd4},
      {1'b0,1'b0,8'h00,1'b1,8'h00,4'd4},
      {1'b1,1'b1,8'h05,1'b0,8'h00,4'd4},
      {1'b0,1'b0,8'h00,1'b1,8'h00,4'd4},
      {1'b1,1'b1,8'h00,1'b0,8'h00,4'd4},
      {1'b1,1'b0,8'h00,1'b0,8'h00,4'd4},
      {1'b1,1'b1,8'h01,1'b0,8'h00,4'd4},
      {1'b0,1'b0,8'h00,1'b1,8'h03,4'd4},
      {1'b1,1'b1,8'h2A,1'b0,8'h00,4'd11}, // R11 unmapped
      {1'b0,1'b0,8'h00,1'b1,8'h00,4'd11},
      {1'b0,1'b1,8'h00,1'b1,8'h2A,4'd2}   // R2 index readback
   };

   task automatic acc(input bit d, input bit w, input logic [7:0] a, input logic [7:0] v);
      @(negedge clk);
      we = w;
      addr = a;
      wdata = v;
      if (d) cs_d = 1'b1;
      else   cs_i = 1'b1;
      @(negedge clk);
      cs_i = 1'b0;
      cs_d = 1'b0;
   endtask

   task automatic chk(input bit d, input logic [7:0] exp, input string req);
      logic [7:0] act;
      act = d ? rdata_d : rdata_i;
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", req, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(0, 8'h00, "R1 rdata indexed");
      chk(1, 8'h00, "R1 rdata direct");
      acc(0, 0, 8'h01, 8'h00);
      chk(0, 8'h00, "R1 index register");
      acc(1, 0, 8'h01, 8'h00);
      chk(1, 8'h00, "R1 write pointer");
      acc(1, 0, 8'h05, 8'h00);
      chk(1, 8'h00, "R1 frame counter");

      for (int i = 0; i < NV; i++) begin
         logic [22:0] v;
         v = VEC[i];
         acc(0, v[22], {7'b0, v[21]}, v[20:13]);
         if (v[12]) chk(0, v[11:4], $sformatf("R%0d vector %0d", v[3:0], i));
      end

      // R3 direct addressing
      acc(1, 1, 8'h09, 8'hA5);
      acc(1, 0, 8'h01, 8'h00);
      chk(1, 8'h01, "R3 direct write pointer");
      acc(1, 0, 8'h09, 8'h00);
      chk(1, 8'hA5, "R3 R7 direct pop");
      acc(1, 0, 8'h09, 8'h00);
      acc(1, 0, 8'h03, 8'h00);
      chk(1, 8'h01, "R7 empty pop holds pointer");
      acc(1, 1, 8'h09, 8'h5A);
      chk(1, 8'h01, "R11 rdata holds over write");
      acc(1, 0, 8'hFF, 8'h00);
      chk(1, 8'h00, "R11 unmapped reads zero");

      // R6 fill FIFO 2 to the refusal point
      acc(1, 1, 8'h00, 8'h02);
      acc(1, 0, 8'h00, 8'h00);
      chk(1, 8'h02, "R4 selection readback");
      for (int i = 0; i < 511; i++) acc(1, 1, 8'h09, 8'(i));
      acc(1, 1, 8'h09, 8'hEE);
      acc(1, 0, 8'h01, 8'h00);
      chk(1, 8'hFF, "R6 refused write pointer low");
      acc(1, 0, 8'h02, 8'h00);
      chk(1, 8'h01, "R10 write pointer high");
      acc(1, 0, 8'h09, 8'h00);
      chk(1, 8'h00, "R7 first byte");
      acc(1, 1, 8'h09, 8'h77);
      acc(1, 0, 8'h02, 8'h00);
      chk(1, 8'h01, "R10 high stays latched");
      acc(1, 0, 8'h01, 8'h00);
      chk(1, 8'h00, "R5 write pointer wrap");
      acc(1, 0, 8'h02, 8'h00);
      chk(1, 8'h00, "R10 high relatched");
      acc(1, 0, 8'h09, 8'h00);
      chk(1, 8'h01, "R7 second byte");
      for (int i = 0; i < 509; i++) acc(1, 0, 8'h09, 8'h00);
      acc(1, 0, 8'h03, 8'h00);
      chk(1, 8'hFF, "R10 read pointer low");
      acc(1, 0, 8'h04, 8'h00);
      chk(1, 8'h01, "R10 read pointer high");
      acc(1, 0, 8'h09, 8'h00);
      chk(1, 8'h77, "R5 byte stored at slot 511");
      acc(1, 0, 8'h03, 8'h00);
      chk(1, 8'h00, "R7 read pointer wrap");

      // R8 and R9 frame counters
      acc(1, 0, 8'h07, 8'h00);
      chk(1, 8'h00, "R8 step read data");
      @(negedge clk);
      hdlc_en = 1'b0;
      acc(1, 0, 8'h07, 8'h00);
      acc(1, 0, 8'h08, 8'h00);
      acc(1, 0, 8'h05, 8'h00);
      chk(1, 8'h01, "R9 input counter frozen");
      acc(1, 0, 8'h06, 8'h00);
      chk(1, 8'h00, "R9 output counter frozen");
      @(negedge clk);
      hdlc_en = 1'b1;
      for (int i = 0; i < 15; i++) acc(1, 0, 8'h07, 8'h00);
      acc(1, 0, 8'h05, 8'h00);
      chk(1, 8'h00, "R8 input counter wraps");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule